// File: doc/BRIEF.md
# Cache Presence Bit Tracker

This block holds one presence bit for every line of the last-level cache. A set bit means the line is known to be held in the DRAM cache below as well. When the last-level cache evicts a dirty line, the block uses the bit to pick the writeback command for the DRAM cache. If the bit is set, the tag probe is skipped and only a fill is issued. If the bit is clear, a probe is issued first and then a fill.

The block watches three event streams. The first is last-level-cache fills, each with two flags: whether the data came from a DRAM cache hit, and whether the DRAM cache installed the line. The second is last-level-cache evictions, each with a dirty flag. The third is notifications that the DRAM cache evicted a line; these are already resolved to the matching last-level-cache set and way. Every line is addressed by its set index together with its way. The command for an eviction appears one clock after the eviction is presented.

Top module: `presence_tracker`

## Requirements
- R1: After reset every presence bit is clear and `wb_cmd_o` is 2'b00. A dirty eviction of a line that has not been filled since reset gives 2'b10.
- R2: A dirty eviction of a line whose presence bit is set gives `wb_cmd_o` = 2'b01 (fill only) in the next cycle.
- R3: A dirty eviction of a line whose presence bit is clear gives `wb_cmd_o` = 2'b10 (probe, then fill) in the next cycle.
- R4: A clean eviction, and any cycle with no eviction, gives `wb_cmd_o` = 2'b00 in the next cycle.
- R5: A fill with `fill_dc_hit_i` or `fill_dc_install_i` high sets the presence bit of the addressed line.
- R6: A fill with both flags low (a bypassed fill) clears the presence bit of the addressed line.
- R7: A DRAM cache eviction notification clears the presence bit of the addressed line.
- R8: When a fill and a clearing event target the same line in the same cycle, the fill decides the bit's new value.
- R9: An eviction uses the bit value from before any update made in the same cycle. The eviction then clears the bit, unless a fill targets the same line in that cycle.
- R10: Lines are addressed by the index {set, way}. An event on one line leaves the bits of all other lines unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_valid_i | input | 1 | Fill event valid |
| fill_set_i | input | 4 | Fill set index |
| fill_way_i | input | 2 | Fill way |
| fill_dc_hit_i | input | 1 | Fill data came from a DRAM cache hit |
| fill_dc_install_i | input | 1 | DRAM cache installed the filled line |
| evict_valid_i | input | 1 | Eviction event valid |
| evict_set_i | input | 4 | Eviction set index |
| evict_way_i | input | 2 | Eviction way |
| evict_dirty_i | input | 1 | Evicted line is dirty |
| dc_evict_valid_i | input | 1 | DRAM cache eviction notification valid |
| dc_evict_set_i | input | 4 | Set of the matching last-level-cache line |
| dc_evict_way_i | input | 2 | Way of the matching last-level-cache line |
| wb_cmd_o | output | 2 | Writeback command: 00 none, 01 fill only, 10 probe then fill |

## Verification
The hardest cases to reach are same-cycle collisions on a single line. These are a fill together with a DRAM cache eviction notice, and an eviction together with a fill to that line. Both depend on the ordering rules in R8 and R9. With uniform random addresses they almost never happen. So about half of the random cycles copy the eviction address onto the fill or notification stream. Directed cycles also build each collision on purpose and then read the resulting bit back through a later dirty eviction.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    WB_NONE        = 2'b00,
    WB_FILL_ONLY   = 2'b01,
    WB_PROBE_FILL  = 2'b10
  } wb_cmd_e;
endpackage

// File: rtl/pt_line_decode.sv
module pt_line_decode #(
  parameter int LINES = 64,
  localparam int LW = $clog2(LINES)
) (
  input  logic          valid_i,
  input  logic [LW-1:0] idx_i,
  output logic [LINES-1:0] sel_o
);
  for (genvar i = 0; i < LINES; i++) begin : g_sel
    assign sel_o[i] = valid_i && (idx_i == LW'(i));
  end
endmodule

// File: rtl/pt_bit_array.sv
module pt_bit_array #(
  parameter int LINES = 64,
  localparam int LW = $clog2(LINES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] fill_sel_i,
  input  logic             fill_val_i,
  input  logic [LINES-1:0] clr_sel_i,
  input  logic [LW-1:0]    rd_idx_i,
  output logic             rd_bit_o
);
  logic [LINES-1:0] bits_q;

  for (genvar i = 0; i < LINES; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            bits_q[i] <= 1'b0;
      else if (fill_sel_i[i]) bits_q[i] <= fill_val_i;  // fill wins
      else if (clr_sel_i[i])  bits_q[i] <= 1'b0;
    end
  end

  assign rd_bit_o = bits_q[rd_idx_i];

  AST_FILL_WRITES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_sel_i != '0) |=> ((bits_q & $past(fill_sel_i)) ==
                            ($past(fill_val_i) ? $past(fill_sel_i) : '0)))
    else $error("fill write"); // R8

  AST_CLEAR_WORKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_sel_i != '0) |=> ((bits_q & $past(clr_sel_i & ~fill_sel_i)) == '0))
    else $error("clear"); // R7

  AST_OTHERS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((bits_q & ~$past(fill_sel_i | clr_sel_i)) ==
              ($past(bits_q) & ~$past(fill_sel_i | clr_sel_i))))
    else $error("untouched line changed"); // R10
endmodule

// File: rtl/pt_cmd_gen.sv
module pt_cmd_gen
  import pt_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     evict_valid_i,
  input  logic     evict_dirty_i,
  input  logic     present_i,
  output wb_cmd_e  cmd_o
);
  wb_cmd_e cmd_d;

  always_comb begin
    cmd_d = WB_NONE;
    if (evict_valid_i && evict_dirty_i)
      cmd_d = present_i ? WB_FILL_ONLY : WB_PROBE_FILL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_o <= WB_NONE;
    else         cmd_o <= cmd_d;
  end
endmodule

// File: rtl/presence_tracker.sv
module presence_tracker
  import pt_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SW = $clog2(SETS),
  localparam int WW = $clog2(WAYS),
  localparam int LINES = SETS * WAYS,
  localparam int LW = SW + WW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fill_valid_i,
  input  logic [SW-1:0] fill_set_i,
  input  logic [WW-1:0] fill_way_i,
  input  logic          fill_dc_hit_i,
  input  logic          fill_dc_install_i,
  input  logic          evict_valid_i,
  input  logic [SW-1:0] evict_set_i,
  input  logic [WW-1:0] evict_way_i,
  input  logic          evict_dirty_i,
  input  logic          dc_evict_valid_i,
  input  logic [SW-1:0] dc_evict_set_i,
  input  logic [WW-1:0] dc_evict_way_i,
  output logic [1:0]    wb_cmd_o
);
  logic [LINES-1:0] fill_sel, dcev_sel, ev_sel;
  logic [LW-1:0]    ev_idx;
  logic             present;
  wb_cmd_e          cmd;

  assign ev_idx = {evict_set_i, evict_way_i};

  pt_line_decode #(.LINES(LINES)) u_dec_fill (
    .valid_i(fill_valid_i), .idx_i({fill_set_i, fill_way_i}), .sel_o(fill_sel));
  pt_line_decode #(.LINES(LINES)) u_dec_dcev (
    .valid_i(dc_evict_valid_i), .idx_i({dc_evict_set_i, dc_evict_way_i}), .sel_o(dcev_sel));
  pt_line_decode #(.LINES(LINES)) u_dec_ev (
    .valid_i(evict_valid_i), .idx_i(ev_idx), .sel_o(ev_sel));

  pt_bit_array #(.LINES(LINES)) u_bits (
    .clk_i, .rst_ni,
    .fill_sel_i(fill_sel),
    .fill_val_i(fill_dc_hit_i | fill_dc_install_i),
    .clr_sel_i(dcev_sel | ev_sel),
    .rd_idx_i(ev_idx),
    .rd_bit_o(present));

  pt_cmd_gen u_cmd (
    .clk_i, .rst_ni,
    .evict_valid_i, .evict_dirty_i,
    .present_i(present),
    .cmd_o(cmd));

  assign wb_cmd_o = cmd;

  AST_FILL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_valid_i && evict_dirty_i && present) |=> (wb_cmd_o == 2'b01))
    else $error("fill only"); // R2
  AST_PROBE_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evict_valid_i && evict_dirty_i && !present) |=> (wb_cmd_o == 2'b10))
    else $error("probe fill"); // R3
  AST_NO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(evict_valid_i && evict_dirty_i) |=> (wb_cmd_o == 2'b00))
    else $error("no cmd"); // R4
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (wb_cmd_o == 2'b00))
    else $error("reset"); // R1
endmodule

// File: tb/sim_presence_tracker.sv
module sim_presence_tracker;
  localparam int SETS = 16, WAYS = 4, SW = 4, WW = 2, LINES = 64;

  logic clk = 0, rst_ni = 0;
  logic fill_valid, fill_hit, fill_inst, ev_valid, ev_dirty, dv;
  logic [SW-1:0] fill_set, ev_set, dset;
  logic [WW-1:0] fill_way, ev_way, dway;
  logic [1:0] wb_cmd;

  int checks = 0, fails = 0;
  bit model [LINES];
  logic [1:0] exp_cmd = 2'b00;
  string exp_tag = "R4";
  bit pending = 0;

  always #5 clk = ~clk;

  presence_tracker #(.SETS(SETS), .WAYS(WAYS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .fill_valid_i(fill_valid), .fill_set_i(fill_set), .fill_way_i(fill_way),
    .fill_dc_hit_i(fill_hit), .fill_dc_install_i(fill_inst),
    .evict_valid_i(ev_valid), .evict_set_i(ev_set), .evict_way_i(ev_way),
    .evict_dirty_i(ev_dirty),
    .dc_evict_valid_i(dv), .dc_evict_set_i(dset), .dc_evict_way_i(dway),
    .wb_cmd_o(wb_cmd));

  function automatic int lidx(logic [SW-1:0] s, logic [WW-1:0] w);
    return int'({s, w});
  endfunction

  function automatic logic [1:0] calc_cmd(bit v, bit d, bit p);
    if (v && d) return p ? 2'b01 : 2'b10;
    return 2'b00;
  endfunction

  task automatic check(logic [1:0] act, logic [1:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: wb_cmd actual %b expected %b", tag, act, exp);
    end
  endtask

  // called at negedge: check previous step, then apply new inputs
  task automatic step(bit fv, int fi, bit fh, bit fn, bit ev, int ei, bit ed,
                      bit d, int di, string tag);
    if (pending) check(wb_cmd, exp_cmd, exp_tag);
    fill_valid = fv; {fill_set, fill_way} = 6'(fi); fill_hit = fh; fill_inst = fn;
    ev_valid = ev; {ev_set, ev_way} = 6'(ei); ev_dirty = ed;
    dv = d; {dset, dway} = 6'(di);
    exp_cmd = calc_cmd(ev, ed, model[ei]);
    exp_tag = (ev && ed) ? tag : (tag == "" ? "R4" : tag);
    if (exp_tag == "") exp_tag = model[ei] ? "R2" : "R3";
    pending = 1;
    if (d)  model[di] = 0;
    if (ev) model[ei] = 0;
    if (fv) model[fi] = fh | fn;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    fill_valid = 0; fill_hit = 0; fill_inst = 0; ev_valid = 0; ev_dirty = 0; dv = 0;
    fill_set = 0; fill_way = 0; ev_set = 0; ev_way = 0; dset = 0; dway = 0;
    foreach (model[i]) model[i] = 0;
    repeat (3) @(negedge clk);
    check(wb_cmd, 2'b00, "R1 reset");
    rst_ni = 1;
    @(negedge clk);
    // R1: untouched line gives probe+fill
    step(0, 0, 0, 0, 1, 3, 1, 0, 0, "R1");
    // R5 + R2: hit fill then dirty evict
    step(1, 5, 1, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 1, 5, 1, 0, 0, "R2 R5 hit");
    // R5 install
    step(1, 12, 0, 1, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 1, 12, 1, 0, 0, "R2 R5 install");
    // R6 bypass
    step(1, 6, 1, 0, 0, 0, 0, 0, 0, "R4");
    step(1, 6, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 1, 6, 1, 0, 0, "R6");
    // R7 dc eviction clears
    step(1, 7, 0, 1, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 1, 7, "R4");
    step(0, 0, 0, 0, 1, 7, 1, 0, 0, "R7");
    // R8 same-cycle fill and dc evict: fill wins
    step(1, 8, 1, 0, 0, 0, 0, 1, 8, "R4");
    step(0, 0, 0, 0, 1, 8, 1, 0, 0, "R8");
    // R9 evict sees old value, same-cycle fill survives
    step(1, 9, 1, 0, 1, 9, 1, 0, 0, "R9 old");
    step(0, 0, 0, 0, 1, 9, 1, 0, 0, "R9 fill kept");
    // R9 clean eviction clears, no command
    step(1, 10, 1, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 1, 10, 0, 0, 0, "R4 clean");
    step(0, 0, 0, 0, 1, 10, 1, 0, 0, "R9 cleared");
    // R10 neighbour untouched
    step(1, 20, 1, 0, 0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 1, 21, 1, 0, 0, "R10");
    step(0, 0, 0, 0, 1, 20, 1, 0, 0, "R10 kept");
    idle();
    // random with biased collisions
    for (int n = 0; n < 4000; n++) begin
      int ei, fi, di;
      bit fv, ev, d, fh, fn, ed;
      ei = int'($urandom_range(LINES - 1));
      fi = ($urandom_range(1) == 1) ? ei : int'($urandom_range(LINES - 1));
      di = ($urandom_range(1) == 1) ? ei : int'($urandom_range(LINES - 1));
      fv = $urandom_range(99) < 50;
      ev = $urandom_range(99) < 50;
      d  = $urandom_range(99) < 25;
      fh = $urandom_range(1) == 1;
      fn = $urandom_range(2) == 0;
      ed = $urandom_range(3) != 0;
      step(fv, fi, fh, fn, ev, ei, ed, d, di, (ev && ed) ? "" : "R4");
    end
    idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule